// File: doc/BRIEF.md
# Store Data Alignment Unit

This block sits between a load/store pipeline and a 32-bit little-endian memory port. It accepts one store request at a time, made of an opcode, an effective address and register data. It turns the request into memory write beats, each with a word-aligned address, per-byte write enables and write data placed in the addressed byte lanes. Byte and halfword data is replicated across the word, so the enables alone pick the lanes that change.

Each access size has its own alignment rule. A request that breaks its rule raises an address-error flag for one cycle, and no write strobe fires. The legacy doubleword store takes the two values of an even/odd register pair as inputs. It writes them as two word beats on consecutive cycles, at the address and at the address plus one word. A busy flag marks both beats. A valid/ready handshake holds off the next request until the second beat has been issued. The register-file read, any cache and the bus protocol belong to other blocks.

Top module: `store_align_unit`

## Requirements
- R1: Opcode 2'b00 (byte) writes bits [7:0] of the even-register input. The enable has only bit addr[1:0] set, and that byte is copied into all four lanes of the write data. A byte store is never misaligned.
- R2: Opcode 2'b01 (halfword) writes bits [15:0] of the even-register input. The enable is 4'b0011 at offset 0 and 4'b1100 at offset 2, and the halfword is copied into both halves of the write data.
- R3: A halfword store with addr[0]=1 raises addr_err for one cycle and produces no write.
- R4: Opcode 2'b10 (word) writes the full even-register input with enable 4'b1111 when addr[1:0]=0. Any other offset raises addr_err and produces no write.
- R5: Opcode 2'b11 (doubleword) with addr[1:0]=0 and an even source register index gives two beats on consecutive cycles. The first writes the even-register input at the address, and the second writes the odd-register input at the address plus 4. Both beats use enable 4'b1111.
- R6: A doubleword store with addr[1:0] other than 0 raises addr_err and produces no beats.
- R7: A doubleword store whose source register index is odd raises pair_err and produces no beats.
- R8: In any cycle where addr_err or pair_err is high, wr_valid is low and wr_be is all zero.
- R9: A request is taken only in a cycle where req_valid and req_ready are both high, and its first beat or error appears in the next cycle. req_ready is low only while a doubleword's second beat has not yet been issued.
- R10: busy is high in exactly the two beat cycles of a doubleword and low in all other cycles.
- R11: wr_addr always equals the request address with bits [1:0] cleared (plus 4 on a doubleword's second beat).
- R12: After reset, wr_valid, wr_be, addr_err, pair_err and busy are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_op | input | 2 | Store size: 00 byte, 01 halfword, 10 word, 11 doubleword |
| req_addr | input | 32 | Effective byte address |
| req_src_idx | input | 5 | Index of the source register |
| req_data_even | input | 32 | Source (even) register value |
| req_data_odd | input | 32 | Odd partner register value, used by doubleword |
| wr_valid | output | 1 | Write beat present |
| wr_addr | output | 32 | Word-aligned write address |
| wr_be | output | 4 | Byte-lane write enables |
| wr_data | output | 32 | Lane-positioned write data |
| addr_err | output | 1 | Misaligned access flag |
| pair_err | output | 1 | Doubleword named an odd register |
| busy | output | 1 | Doubleword beat in progress |

## Verification
The hardest case to reach is a request that arrives while a doubleword's second beat is still pending. The next request has to be held off for exactly one cycle and then taken without a gap. The bench raises req_valid for a byte store in the cycle right after a doubleword is accepted and keeps it raised. It then checks that the second word beat comes out untouched, with ready low, and that the byte beat follows in the next cycle with busy dropped. Error cases are mixed between good stores so that a flag or strobe that stays set would show up.

// File: rtl/store_align_pkg.sv
package store_align_pkg;
  typedef enum logic [1:0] {
    ST_BYTE = 2'b00,
    ST_HALF = 2'b01,
    ST_WORD = 2'b10,
    ST_PAIR = 2'b11
  } st_op_e;
endpackage

// File: rtl/store_lane_pack.sv
module store_lane_pack
  import store_align_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  st_op_e              op,
  input  logic [OFS_W-1:0]    ofs,
  input  logic                src_odd,
  input  logic [DATA_W-1:0]   src_data,
  output logic [LANES-1:0]    lane_be,
  output logic [DATA_W-1:0]   lane_data,
  output logic                misalign,
  output logic                pair_bad
);
  localparam int HALVES = LANES / 2;

  logic [LANES-1:0] be_byte, be_half;
  assign be_byte = LANES'(1) << ofs;
  assign be_half = LANES'(3) << ofs;

  always_comb begin
    lane_be   = '0;
    lane_data = src_data;
    misalign  = 1'b0;
    pair_bad  = 1'b0;
    unique case (op)
      ST_BYTE: begin
        lane_be   = be_byte;
        lane_data = {LANES{src_data[7:0]}};
      end
      ST_HALF: begin
        lane_be   = be_half;
        lane_data = {HALVES{src_data[15:0]}};
        misalign  = ofs[0];
      end
      ST_WORD: begin
        lane_be  = '1;
        misalign = (ofs != '0);
      end
      ST_PAIR: begin
        lane_be  = '1;
        misalign = (ofs != '0);
        pair_bad = src_odd;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/store_beat_seq.sv
module store_beat_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              is_pair,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LANES-1:0]  first_be,
  input  logic [DATA_W-1:0] first_data,
  input  logic [DATA_W-1:0] second_data,
  input  logic              misalign,
  input  logic              pair_bad,
  output logic              can_take,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LANES-1:0]  wr_be,
  output logic [DATA_W-1:0] wr_data,
  output logic              addr_err,
  output logic              pair_err,
  output logic              busy
);
  logic              pend_q;
  logic              second_q;
  logic [ADDR_W-1:0] hold_addr_q;
  logic [DATA_W-1:0] hold_data_q;
  logic [ADDR_W-1:0] aligned;
  logic              any_err;
  logic              start_pair;

  assign aligned    = {base_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign any_err    = misalign | pair_bad;
  assign start_pair = is_pair & ~any_err;
  assign can_take   = ~pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      second_q    <= 1'b0;
      hold_addr_q <= '0;
      hold_data_q <= '0;
      wr_valid    <= 1'b0;
      wr_addr     <= '0;
      wr_be       <= '0;
      wr_data     <= '0;
      addr_err    <= 1'b0;
      pair_err    <= 1'b0;
      busy        <= 1'b0;
    end else if (pend_q) begin
      pend_q   <= 1'b0;
      second_q <= 1'b1;
      wr_valid <= 1'b1;
      wr_addr  <= hold_addr_q;
      wr_be    <= '1;
      wr_data  <= hold_data_q;
      addr_err <= 1'b0;
      pair_err <= 1'b0;
      busy     <= 1'b1;
    end else if (take) begin
      pend_q      <= start_pair;
      second_q    <= 1'b0;
      hold_addr_q <= aligned + ADDR_W'(LANES);
      hold_data_q <= second_data;
      wr_valid    <= ~any_err;
      wr_addr     <= aligned;
      wr_be       <= any_err ? '0 : first_be;
      wr_data     <= first_data;
      addr_err    <= misalign;
      pair_err    <= pair_bad;
      busy        <= start_pair;
    end else begin
      second_q <= 1'b0;
      wr_valid <= 1'b0;
      wr_be    <= '0;
      addr_err <= 1'b0;
      pair_err <= 1'b0;
      busy     <= 1'b0;
    end
  end

  AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (addr_err || pair_err) |-> (!wr_valid && wr_be == '0)); // R8
  AST_PAIR_SECOND_BEAT: assert property (@(posedge clk) disable iff (rst)
    pend_q |=> (wr_valid && busy && wr_be == '1)); // R5
  AST_SECOND_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    second_q |-> (wr_addr == $past(wr_addr) + ADDR_W'(LANES))); // R5
  AST_BUSY_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy); // R10
endmodule

// File: rtl/store_align_unit.sv
module store_align_unit
  import store_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_W-1:0]  req_src_idx,
  input  logic [DATA_W-1:0] req_data_even,
  input  logic [DATA_W-1:0] req_data_odd,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LANES-1:0]  wr_be,
  output logic [DATA_W-1:0] wr_data,
  output logic              addr_err,
  output logic              pair_err,
  output logic              busy
);
  st_op_e             op;
  logic [LANES-1:0]   lane_be;
  logic [DATA_W-1:0]  lane_data;
  logic               misalign;
  logic               pair_bad;
  logic               can_take;
  logic               take;

  assign op        = st_op_e'(req_op);
  assign req_ready = can_take;
  assign take      = req_valid & can_take;

  store_lane_pack #(.DATA_W(DATA_W)) pack_i (
    .op        (op),
    .ofs       (req_addr[OFS_W-1:0]),
    .src_odd   (req_src_idx[0]),
    .src_data  (req_data_even),
    .lane_be   (lane_be),
    .lane_data (lane_data),
    .misalign  (misalign),
    .pair_bad  (pair_bad)
  );

  store_beat_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
    .clk         (clk),
    .rst         (rst),
    .take        (take),
    .is_pair     (op == ST_PAIR),
    .base_addr   (req_addr),
    .first_be    (lane_be),
    .first_data  (lane_data),
    .second_data (req_data_odd),
    .misalign    (misalign),
    .pair_bad    (pair_bad),
    .can_take    (can_take),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_be       (wr_be),
    .wr_data     (wr_data),
    .addr_err    (addr_err),
    .pair_err    (pair_err),
    .busy        (busy)
  );

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_addr[OFS_W-1:0] == '0)); // R11
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> ($countones(wr_be) == 1 || $countones(wr_be) == 2 ||
                  $countones(wr_be) == LANES)); // R1
  AST_STALL_ONLY_IN_PAIR: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> (busy && wr_valid)); // R9
  AST_PAIR_ERR_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    pair_err |-> !busy); // R7
endmodule

// File: tb/store_align_unit_tb.sv
`timescale 1ns/1ps
module store_align_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_op;
  logic [31:0] req_addr;
  logic [4:0]  req_src_idx;
  logic [31:0] req_data_even;
  logic [31:0] req_data_odd;
  logic        wr_valid;
  logic [31:0] wr_addr;
  logic [3:0]  wr_be;
  logic [31:0] wr_data;
  logic        addr_err;
  logic        pair_err;
  logic        busy;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  store_align_unit dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_src_idx(req_src_idx),
    .req_data_even(req_data_even), .req_data_odd(req_data_odd),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
    .addr_err(addr_err), .pair_err(pair_err), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // flags packed as {wr_valid, addr_err, pair_err, busy, ready}
  function automatic logic [31:0] flags();
    return {27'd0, wr_valid, addr_err, pair_err, busy, req_ready};
  endfunction

  task automatic issue(input logic [1:0] op, input logic [31:0] a,
                       input logic [4:0] src, input logic [31:0] ev,
                       input logic [31:0] od);
    @(negedge clk);
    req_op = op; req_addr = a; req_src_idx = src;
    req_data_even = ev; req_data_odd = od; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; req_valid = 1'b0; req_op = 2'b00; req_addr = '0;
    req_src_idx = '0; req_data_even = '0; req_data_odd = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 flags after reset", flags(), 32'h01);
    chk("R12 be after reset", {28'd0, wr_be}, 32'h0);
  endtask

  task automatic t_byte();
    issue(2'b00, 32'h0000_1002, 5'd3, 32'h1122_335A, 32'h0);
    chk("R1 byte flags", flags(), 32'h11);
    chk("R1 byte be", {28'd0, wr_be}, 32'h4);
    chk("R1 byte data", wr_data, 32'h5A5A_5A5A);
    chk("R11 byte addr", wr_addr, 32'h0000_1000);
    issue(2'b00, 32'h0000_1003, 5'd3, 32'h0000_00C7, 32'h0);
    chk("R1 byte top lane be", {28'd0, wr_be}, 32'h8);
    @(negedge clk);
    chk("R9 idle after single beat", flags(), 32'h01);
  endtask

  task automatic t_half();
    issue(2'b01, 32'h0000_2000, 5'd2, 32'hDEAD_BEEF, 32'h0);
    chk("R2 half low be", {28'd0, wr_be}, 32'h3);
    chk("R2 half low data", wr_data, 32'hBEEF_BEEF);
    issue(2'b01, 32'h0000_2002, 5'd2, 32'h0000_1234, 32'h0);
    chk("R2 half high be", {28'd0, wr_be}, 32'hC);
    chk("R2 half high data", wr_data, 32'h1234_1234);
    issue(2'b01, 32'h0000_2003, 5'd2, 32'h0000_1234, 32'h0);
    chk("R3 half odd flags", flags(), 32'h09);
    chk("R8 half odd be", {28'd0, wr_be}, 32'h0);
    @(negedge clk);
    chk("R3 err lasts one cycle", flags(), 32'h01);
  endtask

  task automatic t_word();
    issue(2'b10, 32'h0000_3100, 5'd4, 32'hCAFE_F00D, 32'h0);
    chk("R4 word flags", flags(), 32'h11);
    chk("R4 word be", {28'd0, wr_be}, 32'hF);
    chk("R4 word data", wr_data, 32'hCAFE_F00D);
    issue(2'b10, 32'h0000_3102, 5'd4, 32'hCAFE_F00D, 32'h0);
    chk("R4 word misaligned flags", flags(), 32'h09);
    chk("R11 word err addr", wr_addr, 32'h0000_3100);
  endtask

  task automatic t_pair();
    issue(2'b11, 32'h0000_4008, 5'd6, 32'hAAAA_0001, 32'hBBBB_0002);
    chk("R5 beat0 flags", flags(), 32'h12);
    chk("R5 beat0 addr", wr_addr, 32'h0000_4008);
    chk("R5 beat0 data", wr_data, 32'hAAAA_0001);
    chk("R5 beat0 be", {28'd0, wr_be}, 32'hF);
    @(negedge clk);
    chk("R10 beat1 flags", flags(), 32'h13);
    chk("R5 beat1 addr", wr_addr, 32'h0000_400C);
    chk("R5 beat1 data", wr_data, 32'hBBBB_0002);
    @(negedge clk);
    chk("R10 busy drops", flags(), 32'h01);
  endtask

  task automatic t_pair_errors();
    issue(2'b11, 32'h0000_5004 + 32'h2, 5'd6, 32'h1, 32'h2);
    chk("R6 pair misaligned flags", flags(), 32'h09);
    @(negedge clk);
    chk("R6 no beats after err", flags(), 32'h01);
    issue(2'b11, 32'h0000_5000, 5'd7, 32'h1, 32'h2);
    chk("R7 odd register flags", flags(), 32'h05);
    chk("R8 odd register be", {28'd0, wr_be}, 32'h0);
    @(negedge clk);
    chk("R7 no beats after err", flags(), 32'h01);
  endtask

  task automatic t_backpressure();
    issue(2'b11, 32'h0000_6000, 5'd10, 32'h0101_0101, 32'h0202_0202);
    // keep a byte request up while the second beat is pending
    req_op = 2'b00; req_addr = 32'h0000_7001; req_src_idx = 5'd1;
    req_data_even = 32'h0000_00E1; req_data_odd = 32'h0; req_valid = 1'b1;
    chk("R9 beat0 while held", flags(), 32'h12);
    @(negedge clk);
    chk("R9 beat1 not disturbed", flags(), 32'h13);
    chk("R9 beat1 data", wr_data, 32'h0202_0202);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 held byte taken", flags(), 32'h11);
    chk("R9 held byte be", {28'd0, wr_be}, 32'h2);
    chk("R9 held byte data", wr_data, 32'hE1E1_E1E1);
    @(negedge clk);
    chk("R9 only one take", flags(), 32'h01);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_byte();
    t_half();
    t_word();
    t_pair();
    t_pair_errors();
    t_backpressure();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule